// File: doc/BRIEF.md
# SMBus Master Read Sequencer

This block sequences an SMBus master read at the byte level. Software provides a 7-bit slave address, a byte count, an end-mode switch, a packet-error-check enable and a one-cycle start request. The sequencer then drives a simple bit-level I2C engine through a command handshake. The commands are: generate a START, shift out the address byte, receive a byte and answer it with ACK or NACK, and generate a STOP. While it waits, the sequencer asks the engine to keep SCL low. Each received byte is placed in a data register and raises a ready flag, which the host clears with a read strobe.

The byte count includes the packet-error-check (PEC) byte. When the PEC is enabled, the last byte received is compared with a CRC-8 that the block computes over the address byte and the data bytes. The end-mode switch decides what happens after the last byte. In automatic mode a STOP follows immediately. In software mode the block raises a transfer-complete flag and stretches the clock until the host loads new settings and requests a start. That request produces a repeated START.

The FSM has seven states:

- IDLE: no transfer.
- START: a START or repeated START is being issued.
- ADDR: the address byte is being sent.
- WAIT: the clock is stretched until the data register has been read.
- RECV: a byte is being received.
- STOP: a STOP is being issued.
- HOLD: transfer complete in software end mode, clock held.

The transitions are:

- IDLE→START and HOLD→START on an accepted start request.
- START→ADDR when the engine finishes.
- ADDR→STOP on an address NACK.
- ADDR→STOP or ADDR→HOLD when the count is zero.
- ADDR→WAIT otherwise.
- WAIT→RECV once the data register is empty.
- RECV→WAIT after a byte that is not the last.
- RECV→STOP or RECV→HOLD after the last byte.
- STOP→IDLE when the engine finishes.

Top module: `smbus_rd_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `cmd_valid`, `scl_hold`, `rxne`, `tc`, `pec_err` and `nack_flag` are all low.
- R2: A start request accepted in IDLE issues command code 1 (START). The next command is code 2 (ADDR), with `cmd_byte` equal to the address shifted left by one with bit 0 set to 1 (read).
- R3: Each received byte, whether data or PEC, appears on `rx_data` and sets `rxne`. A `rd_ack` pulse while `rxne` is high clears it on the next cycle.
- R4: The count N includes the PEC byte, and N receive commands (code 3) follow the address. `cmd_nack` is 0 on the first N-1 and 1 on the last.
- R5: In automatic end mode, a STOP (code 4) is issued right after the last byte. The block returns to IDLE when the STOP completes.
- R6: In software end mode, the last byte sets `tc`, and `scl_hold` stays high with no command until a start request arrives. That request latches new settings, clears `tc` and issues a START again.
- R7: No receive command is issued while `rxne` is high. While the block waits for the read, `scl_hold` is high and no command is valid.
- R8: With the PEC enabled, the last byte is compared with a CRC-8 (polynomial 0x07, initial value 0, MSB first) over the address byte and all data bytes. A mismatch sets `pec_err`, and a new start clears it.
- R9: A slave NACK on the address byte is followed by a STOP, sets `nack_flag` and produces no receive command.
- R10: A count of 0 sends only the address. A STOP follows in automatic end mode; in software end mode the block holds with `tc` set.
- R11: A start request arriving while a transfer is in progress (outside IDLE and HOLD) is ignored. The ongoing command sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 7 | Slave address to read from |
| cfg_count | input | 8 | Bytes to receive, PEC included |
| cfg_autoend | input | 1 | 1: automatic STOP, 0: hold for restart |
| cfg_pec_en | input | 1 | Last byte is checked as PEC |
| start_req | input | 1 | One-cycle start request |
| rd_ack | input | 1 | Host read strobe for the data register |
| cmd_valid | output | 1 | Command to the bit engine is valid |
| cmd_op | output | 3 | Command code: 1 START, 2 ADDR, 3 RECV, 4 STOP |
| cmd_byte | output | 8 | Byte to shift out for ADDR |
| cmd_nack | output | 1 | Answer the received byte with NACK |
| eng_done | input | 1 | Engine finished the current command |
| eng_rx_byte | input | 8 | Byte received by the engine, valid with done |
| eng_addr_nak | input | 1 | Slave did not acknowledge the address |
| scl_hold | output | 1 | Engine keeps SCL low |
| rx_data | output | 8 | Received byte register |
| rxne | output | 1 | Received byte not yet read |
| tc | output | 1 | Transfer complete, waiting for restart |
| pec_err | output | 1 | Received PEC did not match |
| nack_flag | output | 1 | Address was not acknowledged |
| busy | output | 1 | A transfer is in progress |

## Verification
The checker assumes the engine raises `eng_done` only while a command is valid, for a single cycle, and returns `eng_addr_nak` only with a finishing address command. It also assumes the host pulses `rd_ack` only while `rxne` is high and pulses `start_req` for one cycle. The bench engine model honours the first two assumptions by answering each command exactly once, after a fixed latency. The bench reader enforces the last two: it strobes only when it has seen `rxne` high, then drops the strobe on the following cycle. Start requests are always generated as single-cycle pulses.

// File: rtl/smbus_rd_pkg.sv
package smbus_rd_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_ADDR  = 3'd2,
        OP_RECV  = 3'd3,
        OP_STOP  = 3'd4
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_WAIT,
        ST_RECV,
        ST_STOP,
        ST_HOLD
    } seq_state_e;

    localparam logic [7:0] PEC_POLY = 8'h07;

endpackage

// File: rtl/smbus_crc8.sv
module smbus_crc8 #(
    parameter int             DATA_W = 8,
    parameter logic [7:0]     POLY   = smbus_rd_pkg::PEC_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [DATA_W-1:0] din,
    output logic [7:0]        crc
);

    logic [7:0] crc_q;
    logic [7:0] crc_nx;

    // Serial CRC over one byte, most significant bit first.
    always_comb begin
        crc_nx = crc_q;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (crc_nx[7] ^ din[b]) begin
                crc_nx = {crc_nx[6:0], 1'b0} ^ POLY;
            end else begin
                crc_nx = {crc_nx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc_nx;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/smbus_byte_ctr.sv
module smbus_byte_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && (rem_q != '0)) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign is_zero = (rem_q == '0);
    assign is_last = (rem_q == ONE);

endmodule

// File: rtl/smbus_rd_fsm.sv
module smbus_rd_fsm
    import smbus_rd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              rd_ack,
    input  logic              cfg_autoend,
    input  logic              cfg_pec_en,
    input  logic [DATA_W-1:0] addr_byte,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_addr_nak,
    input  logic              ctr_zero,
    input  logic              ctr_last,
    input  logic [7:0]        crc_val,
    output logic              take_cfg,
    output logic              ctr_dec,
    output logic              crc_upd,
    output logic [DATA_W-1:0] crc_din,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_nack,
    output logic              scl_hold,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rxne,
    output logic              tc,
    output logic              pec_err,
    output logic              nack_flag
);

    seq_state_e state_q;
    seq_state_e state_nx;

    logic autoend_q;
    logic pec_en_q;
    logic addr_fin;
    logic recv_fin;

    assign take_cfg = start_req && ((state_q == ST_IDLE) || (state_q == ST_HOLD));
    assign addr_fin = (state_q == ST_ADDR) && eng_done;
    assign recv_fin = (state_q == ST_RECV) && eng_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transition logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_cfg) state_nx = ST_START;
            end
            ST_START: begin
                if (eng_done) state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (eng_done) begin
                    if (eng_addr_nak) begin
                        state_nx = ST_STOP;
                    end else if (ctr_zero) begin
                        state_nx = autoend_q ? ST_STOP : ST_HOLD;
                    end else begin
                        state_nx = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!rxne) state_nx = ST_RECV;
            end
            ST_RECV: begin
                if (eng_done) begin
                    if (ctr_last) begin
                        state_nx = autoend_q ? ST_STOP : ST_HOLD;
                    end else begin
                        state_nx = ST_WAIT;
                    end
                end
            end
            ST_STOP: begin
                if (eng_done) state_nx = ST_IDLE;
            end
            ST_HOLD: begin
                if (take_cfg) state_nx = ST_START;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Command and datapath control outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        cmd_byte  = '0;
        cmd_nack  = 1'b0;
        scl_hold  = 1'b0;
        busy      = 1'b1;
        ctr_dec   = 1'b0;
        crc_upd   = 1'b0;
        crc_din   = eng_rx_byte;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_START: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_START;
            end
            ST_ADDR: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_ADDR;
                cmd_byte  = addr_byte;
                crc_din   = addr_byte;
                crc_upd   = eng_done && !eng_addr_nak;
            end
            ST_WAIT: begin
                scl_hold = rxne;
            end
            ST_RECV: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RECV;
                cmd_nack  = ctr_last;
                ctr_dec   = eng_done;
                crc_upd   = eng_done && !ctr_last;
            end
            ST_STOP: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            ST_HOLD: begin
                scl_hold = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // Flags, latched mode bits and the data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoend_q <= 1'b0;
            pec_en_q  <= 1'b0;
            rx_data   <= '0;
            rxne      <= 1'b0;
            tc        <= 1'b0;
            pec_err   <= 1'b0;
            nack_flag <= 1'b0;
        end else begin
            if (take_cfg) begin
                autoend_q <= cfg_autoend;
                pec_en_q  <= cfg_pec_en;
                tc        <= 1'b0;
                pec_err   <= 1'b0;
                nack_flag <= 1'b0;
            end
            if (rd_ack && rxne) begin
                rxne <= 1'b0;
            end
            if (addr_fin) begin
                if (eng_addr_nak) begin
                    nack_flag <= 1'b1;
                end else if (ctr_zero && !autoend_q) begin
                    tc <= 1'b1;
                end
            end
            if (recv_fin) begin
                rx_data <= eng_rx_byte;
                rxne    <= 1'b1;
                if (ctr_last) begin
                    if (pec_en_q) begin
                        pec_err <= (eng_rx_byte != crc_val);
                    end
                    if (!autoend_q) begin
                        tc <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/smbus_rd_seq.sv
module smbus_rd_seq #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    localparam int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_autoend,
    input  logic              cfg_pec_en,
    input  logic              start_req,
    input  logic              rd_ack,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_nack,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_addr_nak,
    output logic              scl_hold,
    output logic [DATA_W-1:0] rx_data,
    output logic              rxne,
    output logic              tc,
    output logic              pec_err,
    output logic              nack_flag,
    output logic              busy
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] addr_byte;
    logic              take_cfg;
    logic              ctr_dec;
    logic              ctr_zero;
    logic              ctr_last;
    logic              crc_upd;
    logic [DATA_W-1:0] crc_din;
    logic [7:0]        crc_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take_cfg) begin
            addr_q <= cfg_addr;
        end
    end

    assign addr_byte = {addr_q, 1'b1};

    smbus_byte_ctr #(
        .CNT_W (CNT_W)
    ) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cfg),
        .load_val (cfg_count),
        .dec      (ctr_dec),
        .is_zero  (ctr_zero),
        .is_last  (ctr_last)
    );

    smbus_crc8 #(
        .DATA_W (DATA_W)
    ) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take_cfg),
        .upd   (crc_upd),
        .din   (crc_din),
        .crc   (crc_val)
    );

    smbus_rd_fsm #(
        .DATA_W (DATA_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .rd_ack       (rd_ack),
        .cfg_autoend  (cfg_autoend),
        .cfg_pec_en   (cfg_pec_en),
        .addr_byte    (addr_byte),
        .eng_done     (eng_done),
        .eng_rx_byte  (eng_rx_byte),
        .eng_addr_nak (eng_addr_nak),
        .ctr_zero     (ctr_zero),
        .ctr_last     (ctr_last),
        .crc_val      (crc_val),
        .take_cfg     (take_cfg),
        .ctr_dec      (ctr_dec),
        .crc_upd      (crc_upd),
        .crc_din      (crc_din),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_byte     (cmd_byte),
        .cmd_nack     (cmd_nack),
        .scl_hold     (scl_hold),
        .busy         (busy),
        .rx_data      (rx_data),
        .rxne         (rxne),
        .tc           (tc),
        .pec_err      (pec_err),
        .nack_flag    (nack_flag)
    );

endmodule

// File: rtl/smbus_rd_seq_chk.sv
module smbus_rd_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ack,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              eng_done,
    input logic              eng_addr_nak,
    input logic              scl_hold,
    input logic              rxne,
    input logic              tc,
    input logic              nack_flag,
    input logic              busy
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !scl_hold && !tc));

    assert_byte_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && eng_done) |=> rxne);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rxne) |=> !rxne);

    assert_stop_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && eng_done) |=> !busy);

    assert_tc_stretches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (scl_hold && !cmd_valid));

    assert_recv_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |-> !rxne);

    assert_hold_no_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> !cmd_valid);

    assert_addr_nak_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && eng_done && eng_addr_nak)
            |=> (cmd_valid && cmd_op == 3'd4 && nack_flag));

endmodule

bind smbus_rd_seq smbus_rd_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_ack       (rd_ack),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .eng_done     (eng_done),
    .eng_addr_nak (eng_addr_nak),
    .scl_hold     (scl_hold),
    .rxne         (rxne),
    .tc           (tc),
    .nack_flag    (nack_flag),
    .busy         (busy)
);

// File: tb/smbus_rd_seq_tb_top.sv
`timescale 1ns/1ps
module smbus_rd_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [7:0] cfg_count = '0;
    logic       cfg_autoend = 1'b0;
    logic       cfg_pec_en = 1'b0;
    logic       start_req = 1'b0;
    logic       rd_ack = 1'b0;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_byte;
    logic       cmd_nack;
    logic       eng_done = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic       eng_addr_nak = 1'b0;
    logic       scl_hold;
    logic [7:0] rx_data;
    logic       rxne;
    logic       tc;
    logic       pec_err;
    logic       nack_flag;
    logic       busy;

    always #5 clk = ~clk;

    smbus_rd_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_addr     (cfg_addr),
        .cfg_count    (cfg_count),
        .cfg_autoend  (cfg_autoend),
        .cfg_pec_en   (cfg_pec_en),
        .start_req    (start_req),
        .rd_ack       (rd_ack),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_byte     (cmd_byte),
        .cmd_nack     (cmd_nack),
        .eng_done     (eng_done),
        .eng_rx_byte  (eng_rx_byte),
        .eng_addr_nak (eng_addr_nak),
        .scl_hold     (scl_hold),
        .rx_data      (rx_data),
        .rxne         (rxne),
        .tc           (tc),
        .pec_err      (pec_err),
        .nack_flag    (nack_flag),
        .busy         (busy)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    // Scoreboard queues: expected command items {op, nack, byte}, their tags,
    // expected host reads, and the bytes the slave model will return.
    logic [11:0] exp_cmd_q[$];
    string       exp_tag_q[$];
    logic [7:0]  exp_rd_q[$];
    logic [7:0]  slave_q[$];
    bit          nak_mode = 1'b0;
    int          read_delay = 2;
    int          hold_cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pec_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    // Bit-engine model and command monitor: answers each command after a
    // fixed latency and compares it with the head of the expected queue.
    int ecnt = 0;
    always @(negedge clk) begin
        logic was_done;
        was_done = eng_done;
        eng_done = 1'b0;
        eng_addr_nak = 1'b0;
        if (!rst_n) begin
            ecnt = 0;
        end else if (cmd_valid && !was_done) begin
            if (ecnt == 2) begin
                logic [11:0] act;
                ecnt = 0;
                act = {cmd_op, (cmd_op == 3'd3) ? cmd_nack : 1'b0,
                       (cmd_op == 3'd2) ? cmd_byte : 8'h00};
                if (exp_cmd_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected command", int'(act), 0);
                end else begin
                    logic [11:0] e;
                    string t;
                    e = exp_cmd_q.pop_front();
                    t = exp_tag_q.pop_front();
                    check(act == e, t, "command {op,nack,byte}", int'(act), int'(e));
                end
                if (cmd_op == 3'd3) begin
                    eng_rx_byte = (slave_q.size() > 0) ? slave_q.pop_front() : 8'hEE;
                end
                if (cmd_op == 3'd2) eng_addr_nak = nak_mode;
                eng_done = 1'b1;
            end else begin
                ecnt++;
            end
        end
    end

    // Host reader: reads the data register after a programmable delay.
    int rwait = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_op == 3'd3 && rxne)
                check(1'b0, "R7", "receive issued while data unread", 1, 0);
            if (scl_hold && rxne && !tc) hold_cycles++;
        end
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rst_n && rxne) begin
            if (rwait >= read_delay) begin
                logic [7:0] e;
                rwait = 0;
                e = (exp_rd_q.size() > 0) ? exp_rd_q.pop_front() : 8'h00;
                check(rx_data == e, "R3", "received byte", rx_data, e);
                rd_ack = 1'b1;
            end else begin
                rwait++;
            end
        end
    end

    // Driver: builds the expected items for one transfer and starts it.
    task automatic xfer(input logic [6:0] a, input int n, input bit ae, input bit pe,
                        input bit corrupt, input bit nak, input bit mid_start);
        logic [7:0] crc;
        logic [7:0] ab;
        ab = {a, 1'b1};
        crc = pec_step(8'h00, ab);
        nak_mode = nak;
        exp_cmd_q.push_back({3'd1, 1'b0, 8'h00}); exp_tag_q.push_back("R2");
        exp_cmd_q.push_back({3'd2, 1'b0, ab});    exp_tag_q.push_back("R2");
        if (nak) begin
            exp_cmd_q.push_back({3'd4, 1'b0, 8'h00}); exp_tag_q.push_back("R9");
        end else begin
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                if (pe && i == n - 1) begin
                    d = corrupt ? (crc ^ 8'h5A) : crc;
                end else begin
                    d = 8'(a * 37 + i * 91 + 21);
                    crc = pec_step(crc, d);
                end
                slave_q.push_back(d);
                exp_rd_q.push_back(d);
                exp_cmd_q.push_back({3'd3, (i == n - 1), 8'h00});
                exp_tag_q.push_back("R4");
            end
            if (ae) begin
                exp_cmd_q.push_back({3'd4, 1'b0, 8'h00});
                exp_tag_q.push_back((n == 0) ? "R10" : "R5");
            end
        end
        @(negedge clk);
        cfg_addr = a; cfg_count = 8'(n); cfg_autoend = ae; cfg_pec_en = pe;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        if (mid_start) begin
            repeat (12) @(negedge clk);
            cfg_addr = 7'h7F; cfg_count = 8'd9; cfg_autoend = 1'b0;
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        do @(negedge clk);
        while (!(exp_cmd_q.size() == 0 && exp_rd_q.size() == 0 && !rxne && !rd_ack
                 && (!busy || tc)));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "R1", "watchdog expired", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!cmd_valid, "R1", "cmd_valid after reset", cmd_valid, 0);
        check(!scl_hold && !rxne, "R1", "hold/rxne after reset", {scl_hold, rxne}, 0);
        check(!tc && !pec_err && !nack_flag, "R1", "flags after reset",
              {tc, pec_err, nack_flag}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Automatic end, 2 data + correct PEC
        xfer(7'h50, 3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check(!pec_err, "R8", "pec_err on matching PEC", pec_err, 0);
        check(!busy && !tc, "R5", "idle after automatic STOP", {busy, tc}, 0);

        // Wrong PEC
        xfer(7'h2B, 4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check(pec_err, "R8", "pec_err on corrupted PEC", pec_err, 1);

        // Software end mode, then repeated start
        xfer(7'h11, 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check(tc, "R6", "tc after last byte", tc, 1);
        check(!pec_err, "R8", "new start cleared pec_err", pec_err, 0);
        repeat (10) @(negedge clk);
        check(scl_hold && !cmd_valid && busy, "R6", "clock held while waiting",
              {scl_hold, cmd_valid, busy}, 3'b101);
        xfer(7'h12, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(!tc && !busy, "R6", "tc cleared by restart", {tc, busy}, 0);

        // Address NACK
        xfer(7'h33, 3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check(nack_flag, "R9", "nack_flag after address NACK", nack_flag, 1);
        check(!rxne && !busy, "R9", "no byte and idle after abort", {rxne, busy}, 0);

        // Count of zero, both end modes
        xfer(7'h05, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(!busy && !nack_flag, "R10", "zero count with STOP", {busy, nack_flag}, 0);
        xfer(7'h06, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(tc && scl_hold, "R10", "zero count held", {tc, scl_hold}, 2'b11);

        // Slow host reads and a stray start request mid-transfer
        read_delay = 15;
        hold_cycles = 0;
        xfer(7'h48, 3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check(hold_cycles > 0, "R7", "clock stretched for unread byte", hold_cycles, 1);
        check(!busy && !pec_err, "R11", "stray start ignored", {busy, pec_err}, 0);
        check(slave_q.size() == 0, "R4", "all slave bytes consumed", slave_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule